// File: doc/BRIEF.md
# Vector Constant Mask Generator

This block builds a 128-bit vector constant from immediate fields in one registered step. It has two modes. In byte-mask mode a 16-bit immediate is widened so that each of its bits becomes a whole byte of ones or zeros. In bit-range mode a start index and an end index pick a contiguous run of ones inside one element. The run may wrap around the end of the element. That element pattern is then copied into every element slot of the vector, at an element size of 8, 16, 32 or 64 bits.

An instruction decoder drives one request at a time through a valid/ready handshake. The result appears one clock later on a registered output. If bit-range mode is given an element-size code that is not supported, the block raises a specification-exception flag in place of a result. Writing the result into a register file happens outside this block.

Top module: `vmask_gen`

## Requirements
- R1: After reset, valid_o is 0, vec_o is all zeros and spec_exc_o is 0.
- R2: In byte-mask mode (mode_i=0), bmask_i bit k drives vector byte 15-k to 0xFF when the bit is 1 and to 0x00 when it is 0. Vector byte 0 is vec_o[127:120], so bmask_i[15:8] controls the left doubleword vec_o[127:64].
- R3: In byte-mask mode no exception is raised, and esize_i, start_i and end_i have no effect on vec_o.
- R4: In bit-range mode (mode_i=1), esize_i codes 0, 1, 2 and 3 select elements of 8, 16, 32 and 64 bits. Any code from 4 to 7 sets spec_exc_o=1 and forces vec_o to all zeros.
- R5: start_i and end_i are each reduced modulo the element width before use, so only their low log2(width) bits count.
- R6: Bit index 0 is the most significant bit of an element. When start<=end, the element has ones at every index from start to end inclusive and zeros at all other indices.
- R7: When start>end, the run wraps: indices start..width-1 and 0..end are ones, and indices end+1..start-1 are zeros.
- R8: When start equals end after reduction, exactly one bit is set in each element.
- R9: The element pattern is replicated into every element slot. Element 0 occupies the most significant bits of vec_o.
- R10: ready_o equals !valid_o || ready_i. A request is accepted when valid_i && ready_o. Its result is on vec_o/spec_exc_o with valid_o=1 in the next cycle. The outputs stay stable while valid_o=1 and ready_i=0.
- R11: When the output is consumed and no new request is accepted, valid_o returns to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| ready_o | output | 1 | Block can accept a request |
| mode_i | input | 1 | 0 = byte-mask, 1 = bit-range |
| bmask_i | input | 16 | Byte-mask immediate |
| start_i | input | 8 | Bit-range start index (raw) |
| end_i | input | 8 | Bit-range end index (raw) |
| esize_i | input | 3 | Element size code for bit-range mode |
| valid_o | output | 1 | Result valid |
| ready_i | input | 1 | Consumer accepts the result |
| vec_o | output | 128 | Generated vector |
| spec_exc_o | output | 1 | Specification exception in place of a result |

## Verification
Every result is due exactly one clock after the edge at which the request is accepted, because there is one output register between the inputs and vec_o. The bench drives each request on a falling edge and holds valid_i over one rising edge. It then reads vec_o, spec_exc_o and valid_o on the next falling edge, which lands half a period after that register loads. Back-pressure cases extend the wait by whole cycles while ready_i is low, and the stability checks sample on each falling edge within that window.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  localparam int VEC_W  = 128;
  localparam int IDX_W  = 8;
  localparam int ES_W   = 3;
  localparam int NUM_ES = 4;

  typedef enum logic {
    MODE_BYTE  = 1'b0,
    MODE_RANGE = 1'b1
  } vmode_e;
endpackage

// File: rtl/vmask_byte_expand.sv
module vmask_byte_expand #(
  parameter int VEC_W = 128,
  localparam int NB = VEC_W / 8
) (
  input  logic [NB-1:0]    bmask_i,
  output logic [VEC_W-1:0] vec_o
);
  // immediate bit k lands in byte 15-k counted from the left, i.e. bits [8k +: 8]
  for (genvar k = 0; k < NB; k++) begin : g_byte
    assign vec_o[k*8 +: 8] = {8{bmask_i[k]}};
  end
endmodule

// File: rtl/vmask_range_elem.sv
module vmask_range_elem #(
  parameter int EW    = 8,
  parameter int IDX_W = 8,
  localparam int IW = $clog2(EW)
) (
  input  logic [IDX_W-1:0] start_i,
  input  logic [IDX_W-1:0] end_i,
  output logic [EW-1:0]    elem_o
);
  logic [IW-1:0] s, e;
  logic          no_wrap;

  assign s       = start_i[IW-1:0];
  assign e       = end_i[IW-1:0];
  assign no_wrap = (s <= e);

  always_comb begin
    for (int i = 0; i < EW; i++) begin
      logic [IW-1:0] idx;
      logic          ge_s, le_e;
      idx  = IW'(i);
      ge_s = (idx >= s);
      le_e = (idx <= e);
      // index 0 is element MSB
      elem_o[EW-1-i] = no_wrap ? (ge_s & le_e) : (ge_s | le_e);
    end
  end
endmodule

// File: rtl/vmask_replicate.sv
module vmask_replicate #(
  parameter int EW    = 8,
  parameter int VEC_W = 128,
  localparam int NE = VEC_W / EW
) (
  input  logic [EW-1:0]    elem_i,
  output logic [VEC_W-1:0] vec_o
);
  for (genvar j = 0; j < NE; j++) begin : g_slot
    assign vec_o[j*EW +: EW] = elem_i;
  end
endmodule

// File: rtl/vmask_gen.sv
module vmask_gen
  import vmask_pkg::*;
#(
  parameter int VEC_W  = vmask_pkg::VEC_W,
  parameter int IDX_W  = vmask_pkg::IDX_W,
  parameter int ES_W   = vmask_pkg::ES_W,
  parameter int NUM_ES = vmask_pkg::NUM_ES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  output logic               ready_o,
  input  logic               mode_i,
  input  logic [VEC_W/8-1:0] bmask_i,
  input  logic [IDX_W-1:0]   start_i,
  input  logic [IDX_W-1:0]   end_i,
  input  logic [ES_W-1:0]    esize_i,
  output logic               valid_o,
  input  logic               ready_i,
  output logic [VEC_W-1:0]   vec_o,
  output logic               spec_exc_o
);
  localparam int SEL_W = (NUM_ES > 1) ? $clog2(NUM_ES) : 1;

  vmode_e           mode;
  logic [VEC_W-1:0] byte_vec;
  logic [VEC_W-1:0] rng_vec [NUM_ES];
  logic [VEC_W-1:0] rng_sel;
  logic             es_ok;
  logic [VEC_W-1:0] vec_d;
  logic             exc_d;

  logic             valid_q;
  logic [VEC_W-1:0] vec_q;
  logic             exc_q;

  assign mode = vmode_e'(mode_i);

  vmask_byte_expand #(.VEC_W(VEC_W)) u_byte (
    .bmask_i (bmask_i),
    .vec_o   (byte_vec)
  );

  for (genvar g = 0; g < NUM_ES; g++) begin : g_es
    localparam int EW = 8 << g;
    logic [EW-1:0] elem;

    vmask_range_elem #(.EW(EW), .IDX_W(IDX_W)) u_elem (
      .start_i (start_i),
      .end_i   (end_i),
      .elem_o  (elem)
    );

    vmask_replicate #(.EW(EW), .VEC_W(VEC_W)) u_rep (
      .elem_i (elem),
      .vec_o  (rng_vec[g])
    );
  end

  assign es_ok   = (esize_i < ES_W'(NUM_ES));
  assign rng_sel = rng_vec[esize_i[SEL_W-1:0]];

  always_comb begin
    vec_d = '0;
    exc_d = 1'b0;
    unique case (mode)
      MODE_BYTE: vec_d = byte_vec;
      MODE_RANGE: begin
        if (es_ok) vec_d = rng_sel;
        else       exc_d = 1'b1;
      end
      default: ;
    endcase
  end

  assign ready_o = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      exc_q   <= 1'b0;
    end else if (ready_o) begin
      valid_q <= valid_i;
      if (valid_i) begin
        vec_q <= vec_d;
        exc_q <= exc_d;
      end
    end
  end

  assign valid_o    = valid_q;
  assign vec_o      = vec_q;
  assign spec_exc_o = exc_q;
endmodule

// File: rtl/vmask_gen_chk.sv
module vmask_gen_chk #(
  parameter int VEC_W  = 128,
  parameter int IDX_W  = 8,
  parameter int ES_W   = 3,
  parameter int NUM_ES = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               ready_o,
  input logic               mode_i,
  input logic [VEC_W/8-1:0] bmask_i,
  input logic [IDX_W-1:0]   start_i,
  input logic [IDX_W-1:0]   end_i,
  input logic [ES_W-1:0]    esize_i,
  input logic               valid_o,
  input logic               ready_i,
  input logic [VEC_W-1:0]   vec_o,
  input logic               spec_exc_o
);
  localparam int NB = VEC_W / 8;

  p_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> valid_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(vec_o) && $stable(spec_exc_o));

  p_drain_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !valid_i |=> !valid_o);

  p_byte_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o && !mode_i |=>
      vec_o[VEC_W-1 -: 8] == {8{$past(bmask_i[NB-1])}});

  p_byte_noexc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o && !mode_i |=> !spec_exc_o);

  p_bad_es_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o && mode_i && (esize_i >= ES_W'(NUM_ES)) |=>
      spec_exc_o && (vec_o == '0));

  p_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o && mode_i && (esize_i == '0) && (start_i[2:0] == end_i[2:0]) |=>
      $countones(vec_o) == NB);
endmodule

bind vmask_gen vmask_gen_chk #(
  .VEC_W(VEC_W), .IDX_W(IDX_W), .ES_W(ES_W), .NUM_ES(NUM_ES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .ready_o    (ready_o),
  .mode_i     (mode_i),
  .bmask_i    (bmask_i),
  .start_i    (start_i),
  .end_i      (end_i),
  .esize_i    (esize_i),
  .valid_o    (valid_o),
  .ready_i    (ready_i),
  .vec_o      (vec_o),
  .spec_exc_o (spec_exc_o)
);

// File: tb/vmask_gen_tb.sv
module vmask_gen_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic         ready_o;
  logic         mode_i = 1'b0;
  logic [15:0]  bmask_i = '0;
  logic [7:0]   start_i = '0;
  logic [7:0]   end_i = '0;
  logic [2:0]   esize_i = '0;
  logic         valid_o;
  logic         ready_i = 1'b1;
  logic [127:0] vec_o;
  logic         spec_exc_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vmask_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .ready_o(ready_o),
    .mode_i(mode_i), .bmask_i(bmask_i), .start_i(start_i), .end_i(end_i),
    .esize_i(esize_i), .valid_o(valid_o), .ready_i(ready_i),
    .vec_o(vec_o), .spec_exc_o(spec_exc_o)
  );

  function automatic logic [127:0] exp_byte(input logic [15:0] m);
    logic [127:0] v = '0;
    for (int b = 0; b < 16; b++)
      if (m[15-b]) v[127-8*b -: 8] = 8'hFF;
    return v;
  endfunction

  function automatic logic [127:0] exp_range(input int es, input int st, input int en);
    logic [127:0] v = '0;
    int w = 8 << es;
    int s = st % w;
    int e = en % w;
    for (int p = 0; p < 128; p++) begin
      int i = (127 - p) % w;
      bit on = (s <= e) ? (i >= s && i <= e) : (i >= s || i <= e);
      v[p] = on;
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic txn(input string req, input logic md, input logic [15:0] bm,
                     input logic [7:0] st, input logic [7:0] en, input logic [2:0] es);
    logic [127:0] ev;
    logic         ee;
    @(negedge clk);
    valid_i = 1'b1; mode_i = md; bmask_i = bm; start_i = st; end_i = en; esize_i = es;
    @(negedge clk);
    valid_i = 1'b0;
    if (!md) begin ev = exp_byte(bm); ee = 1'b0; end
    else if (es > 3) begin ev = '0; ee = 1'b1; end
    else begin ev = exp_range(int'(es), int'(st), int'(en)); ee = 1'b0; end
    check(req, {vec_o[126:0] ^ vec_o[126:0], valid_o}, 128'd1);
    check(req, {vec_o, 1'b0} >> 1, ev);
    check(req, {127'd0, spec_exc_o}, {127'd0, ee});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {vec_o[125:0], valid_o, spec_exc_o}, '0);
    check("R1", vec_o, '0);
    rst_n = 1'b1;

    // R2 byte-mask sweep
    for (int v = 0; v < 65536; v += 13) txn("R2", 1'b0, 16'(v), 8'd0, 8'd0, 3'd0);
    txn("R2", 1'b0, 16'hFF00, 8'd0, 8'd0, 3'd0);
    txn("R2", 1'b0, 16'h0001, 8'd0, 8'd0, 3'd0);
    // R3 range fields ignored in byte mode
    txn("R3", 1'b0, 16'hA5C3, 8'd77, 8'd3, 3'd7);
    txn("R3", 1'b0, 16'h5A3C, 8'd200, 8'd9, 3'd5);

    // R4 bad element size codes
    for (int c = 4; c < 8; c++) txn("R4", 1'b1, 16'hFFFF, 8'd1, 8'd5, 3'(c));

    // R6/R7/R8/R9 range sweep, with raw upper bits for R5
    for (int es = 0; es < 4; es++) begin
      int w = 8 << es;
      for (int s = 0; s < w; s++)
        for (int e = 0; e < w; e++) begin
          string tg = (s == e) ? "R8" : (s > e) ? "R7" : "R6";
          txn(tg, 1'b1, 16'h0, 8'(s + w * ((s + e) % 3)), 8'(e + w * (e % 2)), 3'(es));
        end
    end
    // R5 explicit reduction
    txn("R5", 1'b1, 16'h0, 8'd255, 8'd8, 3'd0);
    // R9 replication with 64-bit elements, run in middle
    txn("R9", 1'b1, 16'h0, 8'd4, 8'd59, 3'd3);

    // R10 back-pressure
    @(negedge clk);
    ready_i = 1'b0; valid_i = 1'b1; mode_i = 1'b0; bmask_i = 16'h8001;
    @(negedge clk);
    valid_i = 1'b0;
    check("R10", {127'd0, valid_o}, 128'd1);
    check("R10", vec_o, exp_byte(16'h8001));
    held = vec_o;
    valid_i = 1'b1; bmask_i = 16'h7FFE;
    @(negedge clk);
    check("R10", {127'd0, ready_o}, 128'd0);
    check("R10", vec_o, held);
    ready_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check("R10", vec_o, exp_byte(16'h7FFE));
    check("R10", {127'd0, valid_o}, 128'd1);
    @(negedge clk);
    // R11 drain
    check("R11", {127'd0, valid_o}, 128'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule